// File: doc/BRIEF.md
# Hint-Driven Return Prediction Unit

This unit executes a privileged return-jump: the new program counter is taken from the integer register selected by the instruction's RB field. The unit sends that register index out to the register file. The value read back must arrive in the same cycle. The lowest bit of that value is not part of the address. It becomes the new privileged-mode flag, and the resolved target is the value with its two low bits cleared.

Alongside, the unit keeps a small circular stack of predicted return addresses. A two-bit hint in the instruction chooses whether the return leaves the stack alone, pops the top entry as its prediction, pushes the fall-through PC, or does both. Call and trap entry logic can also push a PC through a separate plain request pin that is never back-pressured.

Instructions enter through a valid/ready handshake. Results leave through a one-deep registered valid/ready stage. `in_ready` is high whenever the output stage is empty or is being drained in that cycle. While `out_valid` is high and `out_ready` is low, the result holds steady and no new instruction is taken, so a stalled instruction has no effect on the stack.

Top module: `ret_jump_predictor`

## Requirements
- R1: `rb_idx` always equals instruction bits [20:16], combinationally.
- R2: One cycle after an instruction is accepted, `out_valid` is high. `out_target` is `rb_value` with bits [1:0] cleared, and `out_priv` equals `rb_value[0]`.
- R3: Hint 2'b10 (bits [15:14]) pops the stack top and reports it as `out_pred`.
- R4: Hint 2'b00 leaves the stack unchanged, reports `out_pred` as zero, and raises `out_mispredict`.
- R5: Hint 2'b01 pushes `fall_pc` without popping, reports `out_pred` as zero, and raises `out_mispredict`.
- R6: Hint 2'b11 pops the top as `out_pred` and then pushes `fall_pc` in the same cycle.
- R7: For hints 2'b10 and 2'b11, `out_mispredict` is high exactly when `out_pred` differs from `out_target`.
- R8: The stack holds DEPTH (8) entries in a circular buffer. A push onto a full stack overwrites the oldest entry, so the last DEPTH pushes pop back in reverse order.
- R9: All entries reset to zero. A pop from an empty stack returns the entry under the pointer and does not move the pointer, so repeated empty pops return the same value.
- R10: A `push_req` in the same cycle as an instruction pop is applied after the pop. In the same cycle it is also applied after the instruction's own fall-through push.
- R11: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all result outputs hold their values.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_instr | input | 32 | Decoded instruction word |
| rb_idx | output | 5 | Register index for the target read |
| rb_value | input | PC_W | Register value read through `rb_idx` |
| fall_pc | input | PC_W | Fall-through PC of the instruction |
| push_req | input | 1 | Call/trap entry push request |
| push_pc | input | PC_W | PC pushed by `push_req` |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_pred | output | PC_W | Predicted target (zero when no prediction) |
| out_target | output | PC_W | Resolved target, low two bits clear |
| out_priv | output | 1 | New privileged-mode flag |
| out_mispredict | output | 1 | Prediction missing or wrong |

## Verification
An external call/trap push and an instruction's stack action can fall in the same cycle. The bench provokes this by raising `push_req` together with an accepted pop-hint instruction, and again with a swap-hint instruction that also pushes its fall-through PC. It judges the outcome from the predictions that later pops report: the popped value must be the entry that was on top before the push, and the pushes must come back in the stated order. Overflow, empty pops and a stall held for several cycles are driven as separate directed cases.

// File: rtl/ret_pred_pkg.sv
package ret_pred_pkg;

  typedef enum logic [1:0] {
    HINT_KEEP = 2'b00,
    HINT_CALL = 2'b01,
    HINT_RET  = 2'b10,
    HINT_SWAP = 2'b11
  } hint_e;

  typedef struct packed {
    logic pop;
    logic push;
    logic predict;
  } stack_op_t;

  localparam int RB_LSB   = 16;
  localparam int RB_W     = 5;
  localparam int HINT_LSB = 14;
  localparam int INSTR_W  = 32;

endpackage

// File: rtl/ret_hint_decode.sv
module ret_hint_decode
  import ret_pred_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic [RB_W-1:0]    rb_idx,
  output hint_e              hint,
  output stack_op_t          op
);

  assign rb_idx = instr[RB_LSB +: RB_W];
  assign hint   = hint_e'(instr[HINT_LSB +: 2]);

  always_comb begin
    op = '0;
    case (hint)
      HINT_KEEP: op = '{pop: 1'b0, push: 1'b0, predict: 1'b0};
      HINT_CALL: op = '{pop: 1'b0, push: 1'b1, predict: 1'b0};
      HINT_RET:  op = '{pop: 1'b1, push: 1'b0, predict: 1'b1};
      HINT_SWAP: op = '{pop: 1'b1, push: 1'b1, predict: 1'b1};
      default:   op = '0;
    endcase
  end

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int PC_W  = 64,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pop_en,
  input  logic            push_a_en,
  input  logic [PC_W-1:0] push_a_pc,
  input  logic            push_b_en,
  input  logic [PC_W-1:0] push_b_pc,
  output logic [PC_W-1:0] top_pc
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W:0]   FULL = (CNT_W+1)'(DEPTH);

  logic [PC_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] tp, tp_a, idx_a, idx_b, tp_n;
  logic [CNT_W-1:0] cnt, cnt_a, cnt_n;
  logic [CNT_W:0]   cnt_sum;
  logic             pop_live;

  function automatic logic [PTR_W-1:0] ptr_up(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dn(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  // Pop first, then instruction push, then external push.
  always_comb begin
    pop_live = pop_en && (cnt != '0);
    tp_a     = pop_live ? ptr_dn(tp) : tp;
    cnt_a    = pop_live ? cnt - 1'b1 : cnt;
    idx_a    = ptr_up(tp_a);
    idx_b    = push_a_en ? ptr_up(idx_a) : idx_a;
    if (push_b_en)      tp_n = idx_b;
    else if (push_a_en) tp_n = idx_a;
    else                tp_n = tp_a;
    cnt_sum  = {1'b0, cnt_a} + (CNT_W+1)'(push_a_en) + (CNT_W+1)'(push_b_en);
    cnt_n    = (cnt_sum > FULL) ? CNT_W'(DEPTH) : cnt_sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tp  <= '0;
      cnt <= '0;
    end else begin
      tp  <= tp_n;
      cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (push_b_en && (idx_b == PTR_W'(i)))
        mem[i] <= push_b_pc;
      else if (push_a_en && (idx_a == PTR_W'(i)))
        mem[i] <= push_a_pc;
    end
  end

  assign top_pc = mem[tp];

  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  assert_full_stays_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(DEPTH) && !pop_en && (push_a_en || push_b_en)) |=> cnt == CNT_W'(DEPTH));

  assert_empty_pop_holds_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && cnt == '0 && !push_a_en && !push_b_en) |=> (tp == $past(tp) && cnt == '0));

  assert_two_pushes_distinct_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_a_en && push_b_en) |-> idx_a != idx_b);

endmodule

// File: rtl/ret_out_stage.sv
module ret_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_stall_blocks_input_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: rtl/ret_jump_predictor.sv
module ret_jump_predictor
  import ret_pred_pkg::*;
#(
  parameter int PC_W  = 64,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  output logic [RB_W-1:0]   rb_idx,
  input  logic [PC_W-1:0]   rb_value,
  input  logic [PC_W-1:0]   fall_pc,
  input  logic              push_req,
  input  logic [PC_W-1:0]   push_pc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PC_W-1:0]   out_pred,
  output logic [PC_W-1:0]   out_target,
  output logic              out_priv,
  output logic              out_mispredict
);

  localparam int RES_W = 2 * PC_W + 2;

  hint_e           hint;
  stack_op_t       op;
  logic            fire;
  logic [PC_W-1:0] top_pc, pred_pc, tgt_pc;
  logic            miss;
  logic [RES_W-1:0] res_in, res_out;

  ret_hint_decode u_dec (
    .instr  (in_instr),
    .rb_idx (rb_idx),
    .hint   (hint),
    .op     (op)
  );

  assign fire = in_valid && in_ready;

  ret_addr_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop_en    (fire && op.pop),
    .push_a_en (fire && op.push),
    .push_a_pc (fall_pc),
    .push_b_en (push_req),
    .push_b_pc (push_pc),
    .top_pc    (top_pc)
  );

  assign tgt_pc  = {rb_value[PC_W-1:2], 2'b00};
  assign pred_pc = op.predict ? top_pc : '0;
  assign miss    = !op.predict || (top_pc != tgt_pc);
  assign res_in  = {pred_pc, tgt_pc, rb_value[0], miss};

  ret_out_stage #(.W(RES_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_out)
  );

  assign {out_pred, out_target, out_priv, out_mispredict} = res_out;

  assert_target_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_target[1:0] == 2'b00);

  assert_priv_follows_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (out_valid && out_priv == $past(rb_value[0])));

  assert_no_pred_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_instr[HINT_LSB+1]) |=> (out_mispredict && out_pred == '0));

  assert_miss_matches_compare_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pred != '0) |-> (out_mispredict == (out_pred != out_target)));

endmodule

// File: tb/sim_ret_jump_predictor.sv
module sim_ret_jump_predictor;

  localparam int PC_W = 64;
  localparam int NV   = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [31:0]     in_instr = '0;
  logic [4:0]      rb_idx;
  logic [PC_W-1:0] rb_value = '0;
  logic [PC_W-1:0] fall_pc = '0;
  logic            push_req = 1'b0;
  logic [PC_W-1:0] push_pc = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [PC_W-1:0] out_pred, out_target;
  logic            out_priv, out_mispredict;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ret_jump_predictor #(.PC_W(PC_W), .DEPTH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .rb_idx(rb_idx), .rb_value(rb_value), .fall_pc(fall_pc),
    .push_req(push_req), .push_pc(push_pc), .out_valid(out_valid),
    .out_ready(out_ready), .out_pred(out_pred), .out_target(out_target),
    .out_priv(out_priv), .out_mispredict(out_mispredict)
  );

  // {hint, rb_value, fall_pc, exp_pred, exp_target, exp_priv, exp_miss}
  localparam logic [67:0] VEC [NV] = '{
    {2'b01, 16'h1001, 16'h0104, 16'h0000, 16'h1000, 1'b1, 1'b1},
    {2'b01, 16'h2000, 16'h0208, 16'h0000, 16'h2000, 1'b0, 1'b1},
    {2'b00, 16'h3003, 16'h0300, 16'h0000, 16'h3000, 1'b1, 1'b1},
    {2'b11, 16'h0208, 16'h0404, 16'h0208, 16'h0208, 1'b0, 1'b0},
    {2'b10, 16'h0405, 16'h0000, 16'h0404, 16'h0404, 1'b1, 1'b0},
    {2'b10, 16'h0503, 16'h0000, 16'h0104, 16'h0500, 1'b1, 1'b1},
    {2'b10, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0}
  };

  function automatic logic [31:0] mk(input logic [1:0] h, input logic [4:0] r);
    return {6'h1E, 5'd0, r, h, 14'd0};
  endfunction

  task automatic chk(input string tag, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; push_req = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Present one instruction (optionally with an external push), leave outputs for sampling.
  task automatic op(input logic [1:0] h, input logic [4:0] r, input logic [PC_W-1:0] rb,
                    input logic [PC_W-1:0] fall, input logic pv, input logic [PC_W-1:0] pp);
    @(negedge clk);
    in_instr = mk(h, r); rb_value = rb; fall_pc = fall;
    in_valid = 1'b1; push_req = pv; push_pc = pp;
    #1 chk("R1 rb_idx", PC_W'(rb_idx), PC_W'(r));
    @(negedge clk);
    in_valid = 1'b0; push_req = 1'b0;
  endtask

  task automatic ext_push(input logic [PC_W-1:0] pp);
    @(negedge clk);
    push_req = 1'b1; push_pc = pp;
    @(negedge clk);
    push_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R12: reset state
    do_reset();
    chk("R12 out_valid", PC_W'(out_valid), '0);
    chk("R12 in_ready", PC_W'(in_ready), 1);

    // Table: R2 R3 R4 R5 R6 R7 R9
    for (int k = 0; k < NV; k++) begin
      logic [67:0] v;
      v = VEC[k];
      op(v[67:66], 5'(k + 3), PC_W'(v[65:50]), PC_W'(v[49:34]), 1'b0, '0);
      chk("R2 out_valid", PC_W'(out_valid), 1);
      chk("R3/R6 out_pred", out_pred, PC_W'(v[33:18]));
      chk("R2 out_target", out_target, PC_W'(v[17:2]));
      chk("R2 out_priv", PC_W'(out_priv), PC_W'(v[1]));
      chk("R7 out_mispredict", PC_W'(out_mispredict), PC_W'(v[0]));
    end

    // R8: nine pushes into eight entries, oldest lost
    do_reset();
    for (int k = 1; k <= 9; k++) ext_push(PC_W'(64'h100 + k * 16));
    for (int j = 1; j <= 8; j++) begin
      logic [PC_W-1:0] e;
      e = PC_W'(64'h100 + (10 - j) * 16);
      op(2'b10, 5'd1, e, '0, 1'b0, '0);
      chk("R8 overflow pop order", out_pred, e);
      chk("R7 hit", PC_W'(out_mispredict), 0);
    end
    // R9: empty pops repeat the entry under the pointer
    for (int j = 0; j < 2; j++) begin
      op(2'b10, 5'd2, '0, '0, 1'b0, '0);
      chk("R9 empty pop value", out_pred, PC_W'(64'h190));
    end

    // R10: external push colliding with pop, then with swap
    do_reset();
    ext_push(PC_W'(64'h0A00));
    op(2'b10, 5'd4, PC_W'(64'h0A00), '0, 1'b1, PC_W'(64'h0B00));
    chk("R10 pop before push", out_pred, PC_W'(64'h0A00));
    op(2'b10, 5'd4, PC_W'(64'h0B00), '0, 1'b0, '0);
    chk("R10 pushed after pop", out_pred, PC_W'(64'h0B00));
    op(2'b11, 5'd5, '0, PC_W'(64'h0C00), 1'b1, PC_W'(64'h0D00));
    chk("R10 swap on empty", out_pred, '0);
    op(2'b10, 5'd6, PC_W'(64'h0D00), '0, 1'b0, '0);
    chk("R10 external push on top", out_pred, PC_W'(64'h0D00));
    op(2'b10, 5'd6, PC_W'(64'h0C00), '0, 1'b0, '0);
    chk("R10 fall-through below", out_pred, PC_W'(64'h0C00));

    // R11: back-pressure holds result and blocks input
    do_reset();
    out_ready = 1'b0;
    op(2'b01, 5'd7, PC_W'(64'h7001), PC_W'(64'h0700), 1'b0, '0);
    chk("R11 result valid", PC_W'(out_valid), 1);
    in_instr = mk(2'b10, 5'd8); rb_value = PC_W'(64'h0700); in_valid = 1'b1;
    #1 chk("R11 in_ready low", PC_W'(in_ready), 0);
    repeat (2) @(negedge clk);
    chk("R11 target held", out_target, PC_W'(64'h7000));
    chk("R11 priv held", PC_W'(out_priv), 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 stalled op ran once", out_pred, PC_W'(64'h0700));
    chk("R11 hit after stall", PC_W'(out_mispredict), 0);

    finish_run();
  end

endmodule